// File: doc/BRIEF.md
# Byte-Wise Serial Bus Master Transmit Sequencer

This block runs the master-transmitter side of a two-wire open-drain serial bus one byte at a time. A host register block hands it a START request flag, a STOP request flag, a byte to send and a one-cycle pulse that marks a write of the control register. The sequencer generates START, repeated START, STOP and byte-plus-acknowledge sequences on the SDA and SCL lines. It uses a quarter-bit strobe from an external clock divider to pace each step, and it waits whenever another device stretches SCL.

After each protocol step the sequencer loads a status byte. The upper six bits hold the code and the two low bits are always zero. It then raises its interrupt flag and freezes, holding SCL low where the protocol allows. The host inspects the status, optionally loads a new byte, sets the request flags and writes the control register. That write clears the interrupt and picks the next step. Two further conditions are reported: losing arbitration and an SCL stuck-low time-out from the clock block. When the address byte requests a read, the sequencer reports whether the address was acknowledged and goes no further into the receive phase.

Top module: `i2cm_tx_engine`

## Requirements
- R1: After reset, and whenever no step is pending, the status is F8h, the interrupt is low and both lines are released. A control write without the START flag while idle changes none of these.
- R2: A control write with the START flag on a free bus produces SDA falling while SCL is high, then status 08h with the interrupt raised and SCL held low.
- R3: If the bus is busy (a START has been seen on the lines without a later STOP), the START is deferred until a STOP is seen and BUF_QTICKS quarter strobes have then elapsed. The sequencer drives neither line during the wait.
- R4: From status 08h or 10h, a control write sends the byte as the address, MSB first, with bit 0 as the read flag (1 = read). SDA changes only while the sequencer holds SCL low. A write address gives 18h if acknowledged and 20h if not; a read address gives 40h or 48h.
- R5: A data byte is sent MSB first and gives 28h if acknowledged and 30h if not.
- R6: From 18h, 20h, 28h or 30h the pair {START, STOP} picks the next step: 00 sends the next data byte, 10 sends a repeated START that ends in 10h, 01 sends a STOP, and 11 sends a STOP followed by a START (08h) once the bus-free time has passed.
- R7: Completing a STOP pulses the STOP-done output for one cycle and returns the status to F8h with the interrupt low and both lines released.
- R8: If the bus reads low during a bit the sequencer leaves high, status 38h is raised and both lines are released at once. A later control write with the START flag retries from 08h; without it the status returns to F8h.
- R9: In status 40h or 48h, a control write with both flags clear is refused: the status, the interrupt and the SCL hold stay unchanged.
- R10: An SCL time-out strobe while the sequencer is active gives status 78h with the interrupt raised and both lines released. This persists through later control writes until reset.
- R11: While the interrupt is raised in a protocol state, no bit advances and SCL stays held low, however many quarter strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr_i | input | 1 | One-cycle pulse: host wrote the control register |
| sta_i | input | 1 | START request flag from the host |
| sto_i | input | 1 | STOP request flag from the host |
| tx_byte_i | input | BYTE_W | Address or data byte to send |
| qtick_i | input | 1 | Quarter-bit strobe from the clock divider |
| scl_tmo_i | input | 1 | SCL stuck-low time-out strobe |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| irq_o | output | 1 | Serial interrupt flag |
| sto_done_o | output | 1 | One-cycle pulse when a STOP has been sent |
| status_o | output | 8 | Status byte, low two bits zero |

## Verification
The bench builds the sequencer with an 8-bit byte and a bus-free time of 6 quarter strobes, and pulses the quarter strobe every 4 clocks. With these values a deferred START after a foreign bus hold can be timed against a short floor of 24 clocks. The values also let one run go through every status path: both address directions, acknowledged and refused bytes, chained STOP-then-START, arbitration loss with retry, and the time-out lock. A slave model on the wired-AND lines checks each shifted byte and answers or withholds the acknowledge.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    // Six-bit status codes; the status byte is {code, 2'b00}
    localparam logic [5:0] ST_START   = 6'h02;  // 08h
    localparam logic [5:0] ST_RSTART  = 6'h04;  // 10h
    localparam logic [5:0] ST_AW_ACK  = 6'h06;  // 18h
    localparam logic [5:0] ST_AW_NAK  = 6'h08;  // 20h
    localparam logic [5:0] ST_D_ACK   = 6'h0A;  // 28h
    localparam logic [5:0] ST_D_NAK   = 6'h0C;  // 30h
    localparam logic [5:0] ST_LOST    = 6'h0E;  // 38h
    localparam logic [5:0] ST_AR_ACK  = 6'h10;  // 40h
    localparam logic [5:0] ST_AR_NAK  = 6'h12;  // 48h
    localparam logic [5:0] ST_TMO     = 6'h1E;  // 78h
    localparam logic [5:0] ST_IDLE    = 6'h3E;  // F8h

    typedef enum logic [2:0] {
        E_IDLE,
        E_WAITFREE,
        E_START,
        E_BYTE,
        E_STOP,
        E_HOLD,
        E_FAULT
    } eng_e;

endpackage

// File: rtl/i2cm_bus_mon.sv
module i2cm_bus_mon #(
    parameter int BUF_QTICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic qtick_i,
    output logic free_o
);
    localparam int CW = $clog2(BUF_QTICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(BUF_QTICKS);

    typedef struct packed {
        logic          scl_p;
        logic          sda_p;
        logic          busy;
        logic [CW-1:0] cnt;
    } mon_t;

    mon_t r_q, r_d;
    logic start_seen, stop_seen;

    always_comb begin
        r_d        = r_q;
        r_d.scl_p  = scl_i;
        r_d.sda_p  = sda_i;
        start_seen = scl_i && r_q.scl_p && r_q.sda_p && !sda_i;
        stop_seen  = scl_i && r_q.scl_p && !r_q.sda_p && sda_i;
        if (stop_seen) begin
            r_d.busy = 1'b0;
            r_d.cnt  = '0;
        end else if (start_seen) begin
            r_d.busy = 1'b1;
        end else if (!r_q.busy && qtick_i && r_q.cnt != FULL) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{scl_p: 1'b1, sda_p: 1'b1, busy: 1'b0, cnt: FULL};
        end else begin
            r_q <= r_d;
        end
    end

    assign free_o = !r_q.busy && (r_q.cnt == FULL);

    // A START seen on the lines makes the bus unavailable next cycle
    p_start_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_seen |=> !free_o);

endmodule

// File: rtl/i2cm_tx_shift.sv
module i2cm_tx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              step_i,
    output logic              bit_o,
    output logic              ack_slot_o
);
    localparam int IW = $clog2(BYTE_W + 1);
    localparam logic [IW-1:0] LAST = IW'(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [IW-1:0]     idx;
    } shf_t;

    shf_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.sh  = byte_i;
            r_d.idx = '0;
        end else if (step_i) begin
            r_d.sh  = {r_q.sh[BYTE_W-2:0], 1'b0};
            r_d.idx = r_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign bit_o      = r_q.sh[BYTE_W-1];
    assign ack_slot_o = (r_q.idx == LAST);

    // The top never advances past the acknowledge slot
    p_no_step_past_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |-> !ack_slot_o);

endmodule

// File: rtl/i2cm_tx_engine.sv
module i2cm_tx_engine
    import i2cm_pkg::*;
#(
    parameter int BYTE_W     = 8,
    parameter int BUF_QTICKS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  logic              sta_i,
    input  logic              sto_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              qtick_i,
    input  logic              scl_tmo_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe_o,
    output logic              sda_oe_o,
    output logic              irq_o,
    output logic              sto_done_o,
    output logic [7:0]        status_o
);
    typedef struct packed {
        eng_e       st;
        logic [1:0] q;
        logic       sda_lo;
        logic       scl_lo;
        logic       si;
        logic [5:0] code;
        logic       in_master;
        logic       is_addr;
        logic       rd;
        logic       chain;
        logic       ack;
        logic       sto_done;
    } eng_t;

    eng_t r_q, r_d;
    logic bus_free, sh_bit, sh_ack, sh_load, sh_step, qadv;

    i2cm_bus_mon #(.BUF_QTICKS(BUF_QTICKS)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .qtick_i(qtick_i), .free_o(bus_free)
    );

    i2cm_tx_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_i(sh_load), .byte_i(tx_byte_i),
        .step_i(sh_step), .bit_o(sh_bit), .ack_slot_o(sh_ack)
    );

    function automatic logic [5:0] outcome(input logic addr, input logic rd, input logic ack);
        if (addr && rd) return ack ? ST_AR_ACK : ST_AR_NAK;
        if (addr)       return ack ? ST_AW_ACK : ST_AW_NAK;
        return ack ? ST_D_ACK : ST_D_NAK;
    endfunction

    always_comb begin
        r_d          = r_q;
        r_d.sto_done = 1'b0;
        sh_load      = 1'b0;
        sh_step      = 1'b0;
        // quarter 2 is the SCL-high phase: wait for stretching slaves
        qadv = qtick_i && (r_q.q != 2'd2 || scl_i);

        if (scl_tmo_i && r_q.st != E_IDLE && r_q.st != E_FAULT) begin
            r_d.st        = E_FAULT;
            r_d.code      = ST_TMO;
            r_d.si        = 1'b1;
            r_d.sda_lo    = 1'b0;
            r_d.scl_lo    = 1'b0;
            r_d.in_master = 1'b0;
        end else begin
            case (r_q.st)
                E_IDLE: begin
                    if (ctl_wr_i && sta_i) r_d.st = E_WAITFREE;
                end
                E_WAITFREE: begin
                    if (bus_free) begin
                        r_d.st = E_START;
                        r_d.q  = 2'd0;
                    end
                end
                E_START: begin
                    if (qadv) begin
                        r_d.q = r_q.q + 2'd1;
                        case (r_q.q)
                            2'd0: r_d.sda_lo = 1'b0;
                            2'd1: r_d.scl_lo = 1'b0;
                            2'd2: r_d.sda_lo = 1'b1;
                            default: begin
                                r_d.scl_lo    = 1'b1;
                                r_d.st        = E_HOLD;
                                r_d.si        = 1'b1;
                                r_d.code      = r_q.in_master ? ST_RSTART : ST_START;
                                r_d.in_master = 1'b1;
                            end
                        endcase
                    end
                end
                E_BYTE: begin
                    if (qadv) begin
                        r_d.q = r_q.q + 2'd1;
                        case (r_q.q)
                            2'd0: r_d.sda_lo = sh_ack ? 1'b0 : !sh_bit;
                            2'd1: r_d.scl_lo = 1'b0;
                            2'd2: begin
                                if (sh_ack) begin
                                    r_d.ack = !sda_i;
                                end else if (sh_bit && !sda_i) begin
                                    r_d.st        = E_HOLD;
                                    r_d.code      = ST_LOST;
                                    r_d.si        = 1'b1;
                                    r_d.sda_lo    = 1'b0;
                                    r_d.scl_lo    = 1'b0;
                                    r_d.in_master = 1'b0;
                                    r_d.q         = 2'd0;
                                end
                            end
                            default: begin
                                r_d.scl_lo = 1'b1;
                                if (sh_ack) begin
                                    r_d.st      = E_HOLD;
                                    r_d.si      = 1'b1;
                                    r_d.is_addr = 1'b0;
                                    r_d.code    = outcome(r_q.is_addr, r_q.rd, r_q.ack);
                                end else begin
                                    sh_step = 1'b1;
                                end
                            end
                        endcase
                    end
                end
                E_STOP: begin
                    if (qadv) begin
                        r_d.q = r_q.q + 2'd1;
                        case (r_q.q)
                            2'd0: r_d.sda_lo = 1'b1;
                            2'd1: r_d.scl_lo = 1'b0;
                            2'd2: r_d.sda_lo = 1'b0;
                            default: begin
                                r_d.sto_done  = 1'b1;
                                r_d.in_master = 1'b0;
                                r_d.st        = r_q.chain ? E_WAITFREE : E_IDLE;
                            end
                        endcase
                    end
                end
                E_HOLD: begin
                    if (ctl_wr_i) begin
                        if (r_q.code == ST_START || r_q.code == ST_RSTART) begin
                            sh_load     = 1'b1;
                            r_d.rd      = tx_byte_i[0];
                            r_d.is_addr = 1'b1;
                            r_d.st      = E_BYTE;
                        end else if (r_q.code == ST_LOST) begin
                            r_d.st = sta_i ? E_WAITFREE : E_IDLE;
                        end else begin
                            case ({sta_i, sto_i})
                                2'b00: begin
                                    if (r_q.code != ST_AR_ACK && r_q.code != ST_AR_NAK) begin
                                        sh_load     = 1'b1;
                                        r_d.rd      = 1'b0;
                                        r_d.is_addr = 1'b0;
                                        r_d.st      = E_BYTE;
                                    end
                                end
                                2'b10:   r_d.st = E_START;
                                2'b01: begin
                                    r_d.st    = E_STOP;
                                    r_d.chain = 1'b0;
                                end
                                default: begin
                                    r_d.st    = E_STOP;
                                    r_d.chain = 1'b1;
                                end
                            endcase
                        end
                        if (r_d.st != E_HOLD) begin
                            r_d.si   = 1'b0;
                            r_d.code = ST_IDLE;
                            r_d.q    = 2'd0;
                        end
                    end
                end
                default: ;  // E_FAULT holds until reset
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= E_IDLE;
            r_q.code <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign status_o   = {r_q.code, 2'b00};
    assign irq_o      = r_q.si;
    assign scl_oe_o   = r_q.scl_lo;
    assign sda_oe_o   = r_q.sda_lo;
    assign sto_done_o = r_q.sto_done;

    p_idle_no_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 8'hF8) |-> !irq_o);

    p_suspend_holds_scl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && status_o != 8'h38 && status_o != 8'h78) |-> scl_oe_o);

    p_sda_moves_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == E_BYTE && $past(r_q.st) == E_BYTE && r_q.sda_lo != $past(r_q.sda_lo))
        |-> $past(r_q.scl_lo));

    p_stop_returns_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sto_done_o |-> (status_o == 8'hF8 && !irq_o && !scl_oe_o && !sda_oe_o));

    p_lost_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 8'h38) |-> (!sda_oe_o && !scl_oe_o));

    p_timeout_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 8'h78) |=> (status_o == 8'h78 && irq_o));

endmodule

// File: tb/i2cm_tx_engine_tb.sv
`timescale 1ns/1ps
module i2cm_tx_engine_tb;
    localparam int BYTE_W = 8;
    localparam int BUF    = 6;
    localparam int QDIV   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0, sta = 1'b0, sto = 1'b0;
    logic [7:0] txb = '0;
    logic qtick = 1'b0, scl_tmo = 1'b0;
    logic slv_pull = 1'b0, ext_pull = 1'b0, ack_en = 1'b1;
    logic scl_oe, sda_oe, irq, sto_done;
    logic [7:0] status;
    logic scl_ln, sda_ln;
    int n_chk = 0, n_fail = 0, start_cnt = 0;

    always #2.5 clk = ~clk;

    assign scl_ln = ~scl_oe;
    assign sda_ln = ~(sda_oe | slv_pull | ext_pull);

    i2cm_tx_engine #(.BYTE_W(BYTE_W), .BUF_QTICKS(BUF)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .sta_i(sta), .sto_i(sto),
        .tx_byte_i(txb), .qtick_i(qtick), .scl_tmo_i(scl_tmo),
        .scl_i(scl_ln), .sda_i(sda_ln), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
        .irq_o(irq), .sto_done_o(sto_done), .status_o(status)
    );

    // quarter strobe generator
    int qcnt = 0;
    always @(negedge clk) begin
        qcnt  <= (qcnt == QDIV - 1) ? 0 : qcnt + 1;
        qtick <= (qcnt == QDIV - 1);
    end

    task automatic chk(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboards
    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t expq[$];
    logic [7:0] bexp[$];

    // status monitor: compares on each new interrupt event
    logic irq_p = 1'b0;
    logic [7:0] st_p = 8'hF8;
    always @(negedge clk) begin
        if (!rst_n) begin
            irq_p <= 1'b0;
        end else begin
            if (irq && (!irq_p || status != st_p)) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "unexpected status event", status, 8'h00);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(status == e.v, e.tag, status, e.v);
                end
            end
            irq_p <= irq;
            st_p  <= status;
        end
    end

    // slave model on the wired lines
    logic pscl = 1'b1, psda = 1'b1, active = 1'b0, in_ack = 1'b0;
    int bitcnt = 0;
    logic [7:0] rx = '0;
    always @(negedge clk) begin
        if (!rst_n) begin
            active <= 1'b0; in_ack <= 1'b0; slv_pull <= 1'b0; bitcnt <= 0;
        end else begin
            if (scl_ln && pscl && psda && !sda_ln) begin
                active <= 1'b1; bitcnt <= 0; in_ack <= 1'b0;
                start_cnt <= start_cnt + 1;
            end else if (scl_ln && pscl && !psda && sda_ln) begin
                active <= 1'b0; slv_pull <= 1'b0;
            end else if (active && scl_ln && !pscl && bitcnt < 8) begin
                rx <= {rx[6:0], sda_ln};
                bitcnt <= bitcnt + 1;
            end else if (active && !scl_ln && pscl) begin
                if (bitcnt == 8 && !in_ack) begin
                    in_ack <= 1'b1;
                    slv_pull <= ack_en;
                    if (bexp.size() != 0) begin
                        logic [7:0] b;
                        b = bexp.pop_front();
                        chk(rx == b, "R4/R5 shifted byte MSB first", rx, b);
                    end
                end else if (in_ack) begin
                    in_ack <= 1'b0; slv_pull <= 1'b0; bitcnt <= 0;
                end
            end
            pscl <= scl_ln;
            psda <= sda_ln;
        end
    end

    task automatic hwrite(input logic a, input logic o, input logic [7:0] b);
        @(negedge clk);
        sta = a; sto = o; txb = b; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic push(input logic [7:0] v, input string tag);
        exp_t e;
        e.v = v; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic drain(input string tag, output int cyc);
        cyc = 0;
        while (expq.size() != 0 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (expq.size() != 0) begin
            chk(1'b0, tag, status, expq[0].v);
            expq.delete();
        end
    endtask

    task automatic wait_stop(input string tag);
        int c;
        c = 0;
        while (!sto_done && c < 5000) begin
            @(negedge clk);
            c++;
        end
        chk(sto_done, tag, {7'd0, sto_done}, 8'h01);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 8'h00, 8'h01);
        summary();
        $finish;
    end

    initial begin
        int cyc, s0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 8'hF8 && !irq, "R1 reset status", status, 8'hF8);
        chk(!scl_oe && !sda_oe, "R1 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
        hwrite(1'b0, 1'b0, 8'hFF);
        repeat (40) @(negedge clk);
        chk(status == 8'hF8 && !irq && !scl_oe && !sda_oe, "R1 write without START ignored", status, 8'hF8);

        // R2 START on free bus
        s0 = start_cnt;
        push(8'h08, "R2 START status");
        hwrite(1'b1, 1'b0, 8'h00);
        drain("R2 no START status", cyc);
        chk(start_cnt == s0 + 1, "R2 START seen on lines", 8'(start_cnt - s0), 8'h01);
        // R11 frozen while interrupt set
        repeat (50) @(negedge clk);
        chk(status == 8'h08 && irq && scl_oe, "R11 suspended holds SCL low", status, 8'h08);

        // R4 write address acknowledged
        bexp.push_back(8'hA4);
        push(8'h18, "R4 write address ACK");
        hwrite(1'b0, 1'b0, 8'hA4);
        drain("R4 no address status", cyc);

        // R5 and R6 00: data acknowledged then refused
        bexp.push_back(8'h5B);
        push(8'h28, "R5 data ACK");
        hwrite(1'b0, 1'b0, 8'h5B);
        drain("R5 no data status", cyc);
        ack_en = 1'b0;
        bexp.push_back(8'hC3);
        push(8'h30, "R5 data NACK");
        hwrite(1'b0, 1'b0, 8'hC3);
        drain("R5 no data status", cyc);
        ack_en = 1'b1;

        // R6 repeated START
        push(8'h10, "R6 repeated START");
        hwrite(1'b1, 1'b0, 8'h00);
        drain("R6 no repeated START status", cyc);

        // R4 read address, then R9 refused write
        bexp.push_back(8'h91);
        push(8'h40, "R4 read address ACK");
        hwrite(1'b0, 1'b0, 8'h91);
        drain("R4 no read status", cyc);
        hwrite(1'b0, 1'b0, 8'h77);
        repeat (40) @(negedge clk);
        chk(status == 8'h40 && irq && scl_oe, "R9 flags 00 refused after read", status, 8'h40);

        // R7 STOP
        hwrite(1'b0, 1'b1, 8'h00);
        wait_stop("R7 STOP done pulse");
        chk(status == 8'hF8 && !irq && !scl_oe && !sda_oe, "R7 idle after STOP", status, 8'hF8);

        // R4 write address refused, R6 STOP then START
        push(8'h08, "R2 START status");
        hwrite(1'b1, 1'b0, 8'h00);
        drain("R2 no START status", cyc);
        ack_en = 1'b0;
        bexp.push_back(8'h32);
        push(8'h20, "R4 write address NACK");
        hwrite(1'b0, 1'b0, 8'h32);
        drain("R4 no address status", cyc);
        ack_en = 1'b1;
        push(8'h08, "R6 STOP then START");
        hwrite(1'b1, 1'b1, 8'h00);
        wait_stop("R6 STOP before chained START");
        drain("R6 no chained START", cyc);

        // R8 arbitration loss and retry
        ext_pull = 1'b1;
        push(8'h38, "R8 arbitration lost");
        hwrite(1'b0, 1'b0, 8'h80);
        drain("R8 no lost status", cyc);
        chk(!scl_oe && !sda_oe, "R8 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
        repeat (4) @(negedge clk);
        ext_pull = 1'b0;
        push(8'h08, "R8 retry START");
        hwrite(1'b1, 1'b0, 8'h00);
        drain("R8 no retry", cyc);
        bexp.push_back(8'h10);
        push(8'h18, "R4 address after retry");
        hwrite(1'b0, 1'b0, 8'h10);
        drain("R4 no address status", cyc);
        hwrite(1'b0, 1'b1, 8'h00);
        wait_stop("R7 STOP done pulse");

        // R3 busy bus defers START
        repeat (10) @(negedge clk);
        ext_pull = 1'b1;
        repeat (5) @(negedge clk);
        push(8'h08, "R3 deferred START");
        hwrite(1'b1, 1'b0, 8'h00);
        repeat (100) @(negedge clk);
        chk(!irq && !sda_oe && !scl_oe, "R3 no START while busy", status, 8'hF8);
        ext_pull = 1'b0;
        drain("R3 START never issued", cyc);
        chk(cyc >= BUF * QDIV, "R3 bus-free time respected", 8'(cyc), 8'(BUF * QDIV));

        // R10 time-out lock
        @(negedge clk);
        scl_tmo = 1'b1;
        push(8'h78, "R10 time-out status");
        @(negedge clk);
        scl_tmo = 1'b0;
        drain("R10 no time-out status", cyc);
        chk(!scl_oe && !sda_oe, "R10 lines released", {6'd0, scl_oe, sda_oe}, 8'h00);
        hwrite(1'b1, 1'b1, 8'h00);
        repeat (20) @(negedge clk);
        chk(status == 8'h78 && irq, "R10 persists through writes", status, 8'h78);

        // R1 reset clears
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(status == 8'hF8 && !irq && !scl_oe && !sda_oe, "R1 reset clears time-out", status, 8'hF8);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        summary();
        $finish;
    end
endmodule